// File: doc/BRIEF.md
# Pattern-Triggered Bus Trace Recorder

This block sits beside a processor bus and looks at the address, data and control lines on every clock edge. A small bank of pattern slots holds a value and a care mask each. When the sampled bus matches an enabled slot, the recorder writes one entry into an on-chip ring buffer. The entry holds the slot number, the 32-bit bus data word and the current timestamp. A typical use is to place two distinct no-op instruction encodings at the start and at the end of a software routine. Each execution of the routine then leaves a pair of time-stamped entries, and the difference between the two stamps is the time spent in the routine.

Software programs the slots and pulses `arm`. The recorder then captures until `stop` is pulsed. If the halt-when-full option is set, capture also ends when the buffer fills. If the option is clear, the recorder keeps going, overwrites its oldest entries and raises a sticky overflow flag. The timestamp restarts at zero on arm and advances by a programmable step on every clock, so a step equal to the clock period in nanoseconds gives nanosecond stamps. Once capture has ended, a synchronous read port returns entries by logical index, with index 0 being the oldest entry kept. The port also reports how many entries are valid. The buffer depth is a parameter, and a depth exponent of 17 gives 128K entries.

Top module: `trace_capture`

## Requirements
- R1: After reset, `armed`, `overflow` and `entry_count` are all zero.
- R2: Slot k matches when `pat_en[k]` is 1 and `((vec ^ value_k) & care_k) == 0`. Here `vec = {bus_ctrl, bus_addr, bus_data}`, so data sits in bits [31:0], address in [63:32] and control in [67:64]. Slot k's value and care occupy bits [k*68 +: 68] of `pat_value` and `pat_care`.
- R3: When several slots match in the same cycle, the lowest-numbered slot wins, and its number is the one stored in the entry.
- R4: An entry is written only in a cycle where the recorder is armed and some enabled slot matches. A disabled slot never causes a write. While disarmed, `entry_count` does not change.
- R5: The timestamp is 0 in the first cycle after the arm cycle and increases by `TS_STEP` every cycle. Each entry stores the timestamp of the cycle in which its bus value was sampled, together with `bus_data`.
- R6: A cycle with `arm` high sets `armed`, clears `entry_count` and `overflow`, and captures nothing.
- R7: A cycle with `stop` high (and `arm` low) clears `armed` and captures nothing.
- R8: With `stop_on_full` at 1, the write that fills the buffer also clears `armed`. `entry_count` then stays at the depth and `overflow` stays 0.
- R9: With `stop_on_full` at 0, a write into a full buffer replaces the oldest entry. `entry_count` stays at the depth, and `overflow` becomes 1 and stays 1 until the next arm.
- R10: While disarmed, `rd_slot`, `rd_word` and `rd_ts` show, one cycle after `rd_idx` is presented, the entry at logical index `rd_idx`. Index 0 is the oldest entry kept.
- R11: `entry_count` changes by at most one per cycle outside arm cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start a new capture run |
| stop | input | 1 | End the capture run |
| stop_on_full | input | 1 | Halt capture when the buffer fills |
| bus_addr | input | ADDR_W | Sampled bus address |
| bus_data | input | 32 | Sampled bus data word |
| bus_ctrl | input | CTRL_W | Sampled bus control lines |
| pat_en | input | N_SLOTS | Per-slot enable |
| pat_value | input | N_SLOTS*(CTRL_W+ADDR_W+32) | Packed slot match values |
| pat_care | input | N_SLOTS*(CTRL_W+ADDR_W+32) | Packed slot care masks |
| armed | output | 1 | Capture is active |
| overflow | output | 1 | Sticky: entries were overwritten |
| entry_count | output | DEPTH_LOG2+1 | Number of valid entries |
| rd_idx | input | DEPTH_LOG2 | Logical read index |
| rd_slot | output | 2 | Slot number of the entry read |
| rd_word | output | 32 | Bus data word of the entry read |
| rd_ts | output | 32 | Timestamp of the entry read |

## Verification
The slots are loaded with two full-word markers that also require a specific control code, an address-range slot that ignores data, and a disabled slot. The bus is driven with words that hit exactly one slot, words that hit both a marker slot and the address slot (this shows the priority order), the disabled slot's word (this shows that enables gate capture), and a marker word paired with the wrong control code (this shows that control bits take part in the match). Random background traffic sits in between. The same traffic is run three ways: with few hits and no wrap, with many hits and wrap enabled (this shows that the oldest entries are dropped, that logical indexing rotates, and that overflow is sticky), and with halt-when-full (this shows the automatic disarm). Markers are also presented after a stop to confirm that nothing is captured while disarmed.

// File: rtl/trace_pkg.sv
package trace_pkg;
   localparam int unsigned WORD_W    = 32;
   localparam int unsigned TS_W      = 32;
   localparam int unsigned ID_W      = 2;
   localparam int unsigned MAX_SLOTS = 1 << ID_W;

   typedef struct packed {
      logic [ID_W-1:0]   slot;
      logic [WORD_W-1:0] word;
      logic [TS_W-1:0]   ts;
   } trace_entry_t;
endpackage

// File: rtl/trace_match.sv
module trace_match
   import trace_pkg::*;
#(
   parameter int unsigned N_SLOTS = 4,
   parameter int unsigned MATCH_W = 68
) (
   input  logic [MATCH_W-1:0]         bus_vec,
   input  logic [N_SLOTS-1:0]         pat_en,
   input  logic [N_SLOTS*MATCH_W-1:0] pat_value,
   input  logic [N_SLOTS*MATCH_W-1:0] pat_care,
   output logic                       hit,
   output logic [ID_W-1:0]            hit_id
);
   logic [N_SLOTS-1:0] slot_hit;

   for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
      logic [MATCH_W-1:0] diff;
      assign diff        = (bus_vec ^ pat_value[g*MATCH_W +: MATCH_W])
                           & pat_care[g*MATCH_W +: MATCH_W];
      assign slot_hit[g] = pat_en[g] && (diff == '0);
   end

   always_comb begin
      hit_id = '0;
      for (int i = N_SLOTS - 1; i >= 0; i--) begin
         if (slot_hit[i]) hit_id = ID_W'(i);
      end
   end

   assign hit = |slot_hit;
endmodule

// File: rtl/trace_ts.sv
module trace_ts
   import trace_pkg::*;
#(
   parameter int unsigned TS_STEP = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   output logic [TS_W-1:0] ts
);
   localparam logic [TS_W-1:0] STEP_V = TS_W'(TS_STEP);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) ts <= '0;
      else               ts <= ts + STEP_V;
   end
endmodule

// File: rtl/trace_store.sv
module trace_store
   import trace_pkg::*;
#(
   parameter int unsigned DEPTH_LOG2 = 10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  wr_en,
   input  trace_entry_t          wr_entry,
   input  logic [DEPTH_LOG2-1:0] rd_idx,
   output trace_entry_t          rd_entry,
   output logic [DEPTH_LOG2:0]   count,
   output logic                  full,
   output logic                  overflow
);
   localparam int unsigned DEPTH = 1 << DEPTH_LOG2;
   localparam int unsigned CNT_W = DEPTH_LOG2 + 1;

   trace_entry_t          mem [DEPTH];
   logic [DEPTH_LOG2-1:0] wptr;
   logic [DEPTH_LOG2-1:0] phys;

   assign full = (count == CNT_W'(DEPTH));
   // once wrapped, the write pointer marks the oldest surviving entry
   assign phys = full ? (wptr + rd_idx) : rd_idx;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wptr     <= '0;
         count    <= '0;
         overflow <= 1'b0;
      end else if (wr_en) begin
         wptr <= wptr + 1'b1;
         if (full) overflow <= 1'b1;
         else      count    <= count + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wptr] <= wr_entry;
      rd_entry <= mem[phys];
   end
endmodule

// File: rtl/trace_capture.sv
module trace_capture
   import trace_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned CTRL_W     = 4,
   parameter int unsigned N_SLOTS    = 4,
   parameter int unsigned DEPTH_LOG2 = 10,
   parameter int unsigned TS_STEP    = 1,
   localparam int unsigned MATCH_W   = CTRL_W + ADDR_W + WORD_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       arm,
   input  logic                       stop,
   input  logic                       stop_on_full,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic [WORD_W-1:0]          bus_data,
   input  logic [CTRL_W-1:0]          bus_ctrl,
   input  logic [N_SLOTS-1:0]         pat_en,
   input  logic [N_SLOTS*MATCH_W-1:0] pat_value,
   input  logic [N_SLOTS*MATCH_W-1:0] pat_care,
   output logic                       armed,
   output logic                       overflow,
   output logic [DEPTH_LOG2:0]        entry_count,
   input  logic [DEPTH_LOG2-1:0]      rd_idx,
   output logic [ID_W-1:0]            rd_slot,
   output logic [WORD_W-1:0]          rd_word,
   output logic [TS_W-1:0]            rd_ts
);
   localparam int unsigned DEPTH = 1 << DEPTH_LOG2;
   localparam int unsigned CNT_W = DEPTH_LOG2 + 1;

   initial begin
      if (N_SLOTS < 1 || N_SLOTS > MAX_SLOTS)
         $error("N_SLOTS must lie in 1..%0d", MAX_SLOTS);
      if (DEPTH_LOG2 < 2 || DEPTH_LOG2 > 17)
         $error("DEPTH_LOG2 must lie in 2..17");
      if (TS_STEP < 1)
         $error("TS_STEP must be at least 1");
   end

   logic         hit;
   logic [ID_W-1:0] hit_id;
   logic [TS_W-1:0] ts_now;
   logic         wr_en;
   logic         last_free;
   logic         buf_full;
   trace_entry_t wr_entry;
   trace_entry_t rd_entry;

   trace_match #(.N_SLOTS(N_SLOTS), .MATCH_W(MATCH_W)) u_match (
      .bus_vec  ({bus_ctrl, bus_addr, bus_data}),
      .pat_en   (pat_en),
      .pat_value(pat_value),
      .pat_care (pat_care),
      .hit      (hit),
      .hit_id   (hit_id)
   );

   trace_ts #(.TS_STEP(TS_STEP)) u_ts (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (arm),
      .ts   (ts_now)
   );

   assign wr_en     = armed && hit && !arm && !stop;
   assign wr_entry  = '{slot: hit_id, word: bus_data, ts: ts_now};
   assign last_free = (entry_count == CNT_W'(DEPTH - 1));

   trace_store #(.DEPTH_LOG2(DEPTH_LOG2)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (arm),
      .wr_en   (wr_en),
      .wr_entry(wr_entry),
      .rd_idx  (rd_idx),
      .rd_entry(rd_entry),
      .count   (entry_count),
      .full    (buf_full),
      .overflow(overflow)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                                  armed <= 1'b0;
      else if (arm)                                armed <= 1'b1;
      else if (stop)                               armed <= 1'b0;
      else if (wr_en && stop_on_full && last_free) armed <= 1'b0;
   end

   assign rd_slot = rd_entry.slot;
   assign rd_word = rd_entry.word;
   assign rd_ts   = rd_entry.ts;
endmodule

// File: rtl/trace_capture_chk.sv
module trace_capture_chk #(
   parameter int unsigned DEPTH_LOG2 = 10,
   parameter int unsigned TS_STEP    = 1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  arm,
   input logic                  stop,
   input logic                  armed,
   input logic                  overflow,
   input logic [DEPTH_LOG2:0]   entry_count,
   input logic [31:0]           ts
);
   localparam int unsigned DEPTH = 1 << DEPTH_LOG2;

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      entry_count <= (DEPTH_LOG2+1)'(DEPTH)); // R9
   AST_ARM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> (entry_count == '0 && !overflow && armed)); // R6
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !arm) |=> overflow); // R9
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !arm |=> (entry_count == $past(entry_count) ||
                entry_count == $past(entry_count) + 1'b1)); // R11
   AST_STOP_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !arm) |=> !armed); // R7
   AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !arm) |=> $stable(entry_count)); // R4
   AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !arm |=> ts == $past(ts) + 32'(TS_STEP)); // R5
endmodule

bind trace_capture trace_capture_chk #(
   .DEPTH_LOG2(DEPTH_LOG2),
   .TS_STEP   (TS_STEP)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .arm        (arm),
   .stop       (stop),
   .armed      (armed),
   .overflow   (overflow),
   .entry_count(entry_count),
   .ts         (ts_now)
);

// File: tb/sim_trace_capture.sv
module sim_trace_capture;
   localparam int DL    = 3;
   localparam int DEPTH = 1 << DL;
   localparam int STEP  = 8;
   localparam int NS    = 4;
   localparam int MW    = 68;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic arm = 1'b0, stop = 1'b0, sof = 1'b0;
   logic [31:0] b_addr = '0, b_data = '0;
   logic [3:0]  b_ctrl = '0;
   logic [NS-1:0]    pat_en = '0;
   logic [NS*MW-1:0] pat_value = '0, pat_care = '0;
   logic armed, overflow;
   logic [DL:0]   entry_count;
   logic [DL-1:0] rd_idx = '0;
   logic [1:0]    rd_slot;
   logic [31:0]   rd_word, rd_ts;

   int checks = 0, fails = 0;
   logic [65:0] m_q[$];
   logic        m_armed = 1'b0, m_ovf = 1'b0;
   logic [31:0] m_ts = '0;

   always #4 clk = ~clk;

   trace_capture #(.ADDR_W(32), .CTRL_W(4), .N_SLOTS(NS), .DEPTH_LOG2(DL),
                   .TS_STEP(STEP)) u0 (
      .clk(clk), .rst_n(rst_n), .arm(arm), .stop(stop), .stop_on_full(sof),
      .bus_addr(b_addr), .bus_data(b_data), .bus_ctrl(b_ctrl),
      .pat_en(pat_en), .pat_value(pat_value), .pat_care(pat_care),
      .armed(armed), .overflow(overflow), .entry_count(entry_count),
      .rd_idx(rd_idx), .rd_slot(rd_slot), .rd_word(rd_word), .rd_ts(rd_ts));

   task automatic chk(string req, logic [65:0] act, logic [65:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // R2 R3: first enabled slot whose cared bits all agree
   function automatic int exp_slot(logic [31:0] a, logic [31:0] d, logic [3:0] c);
      logic [MW-1:0] v = {c, a, d};
      for (int s = 0; s < NS; s++)
         if (pat_en[s] && (((v ^ pat_value[s*MW +: MW]) & pat_care[s*MW +: MW]) == '0))
            return s;
      return -1;
   endfunction

   task automatic tick(logic [31:0] a, logic [31:0] d, logic [3:0] c);
      int s;
      @(negedge clk);
      arm = 0; stop = 0; b_addr = a; b_data = d; b_ctrl = c;
      s = exp_slot(a, d, c);
      if (m_armed && s >= 0) begin
         if (m_q.size() == DEPTH) begin void'(m_q.pop_front()); m_ovf = 1; end
         m_q.push_back({s[1:0], d, m_ts});
         if (sof && m_q.size() == DEPTH) m_armed = 0;
      end
      m_ts += STEP;
   endtask

   task automatic do_arm();
      @(negedge clk);
      arm = 1; stop = 0; b_addr = 0; b_data = 0; b_ctrl = 0;
      m_q.delete(); m_ovf = 0; m_armed = 1; m_ts = 0;
   endtask

   task automatic do_stop();
      @(negedge clk);
      stop = 1; arm = 0; b_addr = 0; b_data = 0; b_ctrl = 0;
      m_armed = 0;
   endtask

   task automatic verify(string req);
      @(negedge clk);
      arm = 0; stop = 0; b_addr = 0; b_data = 0; b_ctrl = 0;
      m_ts += STEP;
      chk({req, " armed"}, 66'(armed), 66'(m_armed));
      chk({req, " count"}, 66'(entry_count), 66'(m_q.size()));
      chk({req, " overflow"}, 66'(overflow), 66'(m_ovf));
   endtask

   task automatic readback(string req);
      for (int i = 0; i < m_q.size(); i++) begin
         @(negedge clk);
         rd_idx = DL'(i);
         @(negedge clk);
         chk({req, " entry"}, {rd_slot, rd_word, rd_ts}, m_q[i]);
      end
   endtask

   task automatic rand_tick();
      logic [31:0] a = $urandom & 32'h7FFF_FFFF;
      logic [31:0] d = $urandom;
      case ($urandom % 8)
         0: tick(a, 32'h0000_0025, 4'h1);
         1: tick(a, 32'h0000_0065, 4'h1);
         2: tick({16'hBFC0, a[15:0]}, d, 4'($urandom));
         3: tick({16'hBFC0, a[15:0]}, 32'h0000_0065, 4'h1);
         4: tick(a, 32'hDEAD_BEEF, 4'h1);
         5: tick(a, 32'h0000_0025, 4'h2);
         default: tick(a, d, 4'($urandom));
      endcase
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240607));
      // slot0 entry marker, slot1 exit marker, slot2 address window, slot3 disabled
      pat_value[0*MW +: MW] = {4'h1, 32'h0, 32'h0000_0025};
      pat_care [0*MW +: MW] = {4'hF, 32'h0, 32'hFFFF_FFFF};
      pat_value[1*MW +: MW] = {4'h1, 32'h0, 32'h0000_0065};
      pat_care [1*MW +: MW] = {4'hF, 32'h0, 32'hFFFF_FFFF};
      pat_value[2*MW +: MW] = {4'h0, 32'hBFC0_0000, 32'h0};
      pat_care [2*MW +: MW] = {4'h0, 32'hFFFF_0000, 32'h0};
      pat_value[3*MW +: MW] = {4'h1, 32'h0, 32'hDEAD_BEEF};
      pat_care [3*MW +: MW] = {4'hF, 32'h0, 32'hFFFF_FFFF};
      pat_en = 4'b0111;
      repeat (3) @(negedge clk);
      rst_n = 1;
      verify("R1 reset");

      // directed: R2 R3 R4 R5 R6
      sof = 0;
      do_arm();
      verify("R6 arm");
      tick(32'h0000_1000, 32'h0000_0025, 4'h1);   // slot0
      tick(32'h0000_1004, 32'h1234_5678, 4'h3);   // miss
      tick(32'h0000_1008, 32'h0000_0025, 4'h2);   // wrong control: R2 miss
      tick(32'h0000_100C, 32'hDEAD_BEEF, 4'h1);   // disabled slot: R4
      tick(32'hBFC0_0010, 32'h0000_0065, 4'h1);   // slot1 and slot2: R3
      tick(32'hBFC0_0020, 32'h0BAD_F00D, 4'h7);   // slot2 only
      tick(32'h0000_2000, 32'h0000_0065, 4'h1);   // slot1
      do_stop();
      verify("R7 stop");
      tick(32'h0000_3000, 32'h0000_0025, 4'h1);   // disarmed: R4
      tick(32'hBFC0_0000, 32'h0000_0065, 4'h1);
      verify("R4 disarmed");
      readback("R5 R10 directed");

      // random with wrap: R9 R10
      do_arm();
      repeat (60) rand_tick();
      do_stop();
      verify("R9 wrap");
      readback("R9 R10 wrapped");
      chk("R9 overflow set", 66'(overflow), 66'(1));

      // rearm clears overflow: R6
      do_arm();
      verify("R6 rearm");

      // halt when full: R8
      sof = 1;
      repeat (60) rand_tick();
      verify("R8 full halt");
      chk("R8 no overflow", 66'(overflow), 66'(0));
      readback("R8 R10 full");

      // second random run with a short wrap-free tail
      sof = 0;
      do_arm();
      repeat (6) rand_tick();
      do_stop();
      verify("R11 short run");
      readback("R10 short run");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule